// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the status byte of an asynchronous serial port. Five sticky flags live in it: transmit-holding-empty, receive-holding-full, overrun, framing error and parity error. It also shows two read-only bits: a transmit-finished level and the multiprocessor bit of the last completed frame. The CPU reaches the byte over a plain strobe bus. The serial engines report through single-cycle event pulses and a few levels.

A flag can never be set by software. Software can clear a flag only after it has seen that flag as 1 on a read strobe. A hardware event that arrives in the same cycle as the clearing write wins over the clear. The block also decides when the receive data register may be loaded. A clean frame loads it and sets receive-full. A frame that arrives while receive-full is still 1 raises overrun instead, and the new data is dropped.

Top module: `ser_status_reg`

## Requirements
- R1: After reset the status byte reads bit 7 = 1 and bits 6, 5, 4, 3, 1 and 0 = 0. Bit 2 shows the transmit-finished input.
- R2: A CPU write never sets a flag. Writing 1 to a flag position leaves that flag unchanged, and bit 0 always reads 0 whatever is written.
- R3: A write of 0 to a flag position clears that flag only if a read strobe returned the flag as 1 earlier and no hardware set has occurred since. Otherwise the write has no effect.
- R4: A hardware set of a flag in the same cycle as a clearing write leaves the flag at 1. After that set, a further write of 0 has no effect until the flag is read again.
- R5: Bit 7 (transmit-holding-empty) becomes 1 one cycle after a transfer pulse. It is held at 1 while transmit-enable is low or standby is high, and writes of 0 cannot clear it in that state.
- R6: A completed frame with no error, while bit 6 is 0, asserts the receive-load strobe in the same cycle and sets bit 6 one cycle later.
- R7: A frame that carries a framing or parity error pulse does not assert the receive-load strobe and does not change bit 6.
- R8: A completed frame while bit 6 is 1 sets bit 5 (overrun), keeps the receive-load strobe low and leaves bit 6 at 1.
- R9: A framing-error pulse sets bit 4 and a parity-error pulse sets bit 3.
- R10: Standby clears bit 6 and suppresses the receive-load strobe. Bits 5, 4 and 3 keep their values.
- R11: Bit 2 follows the transmit-finished input with no delay. Bit 1 takes the received multiprocessor bit on each completed frame and holds it between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | CPU read strobe; arms each flag that reads as 1 |
| wr_stb | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Status byte |
| tx_moved | input | 1 | Pulse: transmit holding data moved into the shifter |
| tx_enable | input | 1 | Transmit-enable level |
| tx_finished | input | 1 | Transmit-finished level, shown on bit 2 |
| rx_done | input | 1 | Pulse: a receive frame completed |
| rx_frame_err | input | 1 | Framing error of the frame completing this cycle |
| rx_parity_err | input | 1 | Parity error of the frame completing this cycle |
| rx_mpb | input | 1 | Multiprocessor bit of the frame completing this cycle |
| standby | input | 1 | Standby level |
| rx_load | output | 1 | Strobe: load the receive data register this cycle |

## Verification
The collision that matters is a clearing CPU write and a hardware set landing on the same flag in the same clock. The bench arms transmit-holding-empty with a read and then drives the zero write and the transfer pulse together. It expects the flag to stay 1, and expects the following zero write to do nothing because the set disarmed the flag. A second collision is a frame completing while receive-full is still 1. Here the bench watches the load strobe within the cycle and checks that overrun rises while receive-full stays 1.

// File: rtl/ser_status_pkg.sv
package ser_status_pkg;

    localparam int DATA_W    = 8;
    localparam int NUM_FLAGS = 5;

    localparam int POS_TXE  = 7;
    localparam int POS_RXF  = 6;
    localparam int POS_OVR  = 5;
    localparam int POS_FRM  = 4;
    localparam int POS_PAR  = 3;
    localparam int POS_TFIN = 2;
    localparam int POS_MPB  = 1;

    typedef enum logic [2:0] {
        FL_TXE = 3'd0,
        FL_RXF = 3'd1,
        FL_OVR = 3'd2,
        FL_FRM = 3'd3,
        FL_PAR = 3'd4
    } flag_id_e;

    typedef struct packed {
        logic done;
        logic frm_err;
        logic par_err;
        logic mpb;
    } rx_evt_t;

    typedef struct packed {
        logic load;
        logic set_rxf;
        logic set_ovr;
        logic set_frm;
        logic set_par;
    } rx_act_t;

    function automatic int flag_pos(input int idx);
        case (idx)
            FL_TXE:  return POS_TXE;
            FL_RXF:  return POS_RXF;
            FL_OVR:  return POS_OVR;
            FL_FRM:  return POS_FRM;
            default: return POS_PAR;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(
        input logic [NUM_FLAGS-1:0] flags,
        input logic                 tfin,
        input logic                 mpb
    );
        logic [DATA_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_FLAGS; i++) r[flag_pos(i)] = flags[i];
        r[POS_TFIN] = tfin;
        r[POS_MPB]  = mpb;
        return r;
    endfunction

endpackage

// File: rtl/ser_flag_cell.sv
module ser_flag_cell #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic hw_set,
    input  logic hw_clr,
    input  logic rd_stb,
    input  logic wr_stb,
    input  logic wr_bit,
    output logic flag
);
    logic flag_q, armed_q;
    logic sw_clear;

    // software clear needs a prior read of 1 with no set since
    assign sw_clear = wr_stb && !wr_bit && armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= RESET_VAL;
            armed_q <= 1'b0;
        end else begin
            if (hw_set)                  flag_q <= 1'b1;
            else if (hw_clr || sw_clear) flag_q <= 1'b0;

            if (hw_set || hw_clr || sw_clear) armed_q <= 1'b0;
            else if (rd_stb && flag_q)        armed_q <= 1'b1;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/ser_rx_gate.sv
module ser_rx_gate
    import ser_status_pkg::*;
(
    input  rx_evt_t evt,
    input  logic    rxf_now,
    input  logic    standby,
    output rx_act_t act
);
    logic clean;

    assign clean = evt.done && !evt.frm_err && !evt.par_err;

    always_comb begin
        act         = '0;
        act.set_frm = evt.frm_err;
        act.set_par = evt.par_err;
        act.set_ovr = evt.done && rxf_now && !standby;
        act.load    = clean && !rxf_now && !standby;
        act.set_rxf = act.load;
    end
endmodule

// File: rtl/ser_status_reg.sv
module ser_status_reg
    import ser_status_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_stb,
    input  logic        wr_stb,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic        tx_moved,
    input  logic        tx_enable,
    input  logic        tx_finished,
    input  logic        rx_done,
    input  logic        rx_frame_err,
    input  logic        rx_parity_err,
    input  logic        rx_mpb,
    input  logic        standby,
    output logic        rx_load
);
    localparam logic [NUM_FLAGS-1:0] RESET_FLAGS = NUM_FLAGS'(1) << FL_TXE;

    rx_evt_t              evt;
    rx_act_t              act;
    logic [NUM_FLAGS-1:0] flags, set_v, clr_v;
    logic                 mpb_q;

    assign evt = '{done: rx_done, frm_err: rx_frame_err,
                   par_err: rx_parity_err, mpb: rx_mpb};

    ser_rx_gate u_gate (
        .evt     (evt),
        .rxf_now (flags[FL_RXF]),
        .standby (standby),
        .act     (act)
    );

    always_comb begin
        set_v         = '0;
        clr_v         = '0;
        set_v[FL_TXE] = tx_moved || !tx_enable || standby;
        set_v[FL_RXF] = act.set_rxf;
        set_v[FL_OVR] = act.set_ovr;
        set_v[FL_FRM] = act.set_frm;
        set_v[FL_PAR] = act.set_par;
        clr_v[FL_RXF] = standby;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        ser_flag_cell #(.RESET_VAL(RESET_FLAGS[g])) u_cell (
            .clk    (clk),
            .rst    (rst),
            .hw_set (set_v[g]),
            .hw_clr (clr_v[g]),
            .rd_stb (rd_stb),
            .wr_stb (wr_stb),
            .wr_bit (wr_data[flag_pos(g)]),
            .flag   (flags[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)          mpb_q <= 1'b0;
        else if (rx_done) mpb_q <= rx_mpb;
    end

    assign rd_data = pack_status(flags, tx_finished, mpb_q);
    assign rx_load = act.load;
endmodule

// File: rtl/ser_status_chk.sv
module ser_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_stb,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       tx_enable,
    input logic       tx_finished,
    input logic       rx_done,
    input logic       rx_frame_err,
    input logic       rx_parity_err,
    input logic       standby,
    input logic       rx_load
);
    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> (rd_data[7:3] == 5'b10000 && rd_data[1:0] == 2'b00));

    assert_bit0_zero_R2: assert property (@(posedge clk) disable iff (rst)
        rd_data[0] == 1'b0);

    assert_rxf_fall_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_data[6]) |-> ($past(standby) || ($past(wr_stb) && !$past(wr_data[6]))));

    assert_txe_forced_R5: assert property (@(posedge clk) disable iff (rst)
        (!tx_enable || standby) |=> rd_data[7]);

    assert_rxf_rise_from_load_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[6]) |-> $past(rx_load));

    assert_no_load_on_error_R7: assert property (@(posedge clk) disable iff (rst)
        rx_load |-> (!rx_frame_err && !rx_parity_err && rx_done));

    assert_no_load_when_full_R8: assert property (@(posedge clk) disable iff (rst)
        rx_load |-> !rd_data[6]);

    assert_ovr_rise_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[5]) |-> $past(rx_done));

    assert_standby_no_load_R10: assert property (@(posedge clk) disable iff (rst)
        standby |-> !rx_load);

    assert_tfin_follow_R11: assert property (@(posedge clk) disable iff (rst)
        rd_data[2] == tx_finished);
endmodule

bind ser_status_reg ser_status_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_stb        (wr_stb),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .tx_enable     (tx_enable),
    .tx_finished   (tx_finished),
    .rx_done       (rx_done),
    .rx_frame_err  (rx_frame_err),
    .rx_parity_err (rx_parity_err),
    .standby       (standby),
    .rx_load       (rx_load)
);

// File: tb/tb_ser_status_reg.sv
module tb_ser_status_reg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_stb = 0, wr_stb = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       tx_moved = 0, tx_enable = 1, tx_finished = 0;
    logic       rx_done = 0, rx_frame_err = 0, rx_parity_err = 0, rx_mpb = 0;
    logic       standby = 0;
    logic       rx_load;

    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_status_reg dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic bus_read(output logic [7:0] v);
        rd_stb = 1; #1 v = rd_data; cyc(); rd_stb = 0;
    endtask

    task automatic bus_write(input logic [7:0] d);
        wr_stb = 1; wr_data = d; cyc(); wr_stb = 0; wr_data = '0;
    endtask

    task automatic frame(input logic fe, input logic pe, input logic mpb, input logic exp_load, input string req);
        rx_done = 1; rx_frame_err = fe; rx_parity_err = pe; rx_mpb = mpb;
        #1 chk(req, {7'd0, rx_load}, {7'd0, exp_load});
        cyc();
        rx_done = 0; rx_frame_err = 0; rx_parity_err = 0; rx_mpb = 0;
    endtask

    task automatic t_reset();
        rst = 1; cyc(); cyc(); rst = 0;
        chk("R1 reset value", rd_data, 8'h80);
    endtask

    task automatic t_write_rules();
        logic [7:0] v;
        bus_write(8'hFF);
        chk("R2 write ones no change", rd_data, 8'h80);
        bus_write(8'h00);
        chk("R3 zero write without read", rd_data, 8'h80);
        bus_read(v);
        chk("R3 read returns set flag", v, 8'h80);
        bus_write(8'h7F);
        chk("R3 zero write after read clears", rd_data, 8'h00);
    endtask

    task automatic t_set_beats_clear();
        logic [7:0] v;
        tx_moved = 1; cyc(); tx_moved = 0;
        chk("R5 transfer sets TXE", rd_data, 8'h80);
        bus_read(v);
        wr_stb = 1; wr_data = 8'h00; tx_moved = 1; cyc();
        wr_stb = 0; tx_moved = 0;
        chk("R4 set wins over clear", rd_data, 8'h80);
        bus_write(8'h00);
        chk("R4 set disarms flag", rd_data, 8'h80);
        bus_read(v); bus_write(8'h00);
        chk("R3 rearm then clear", rd_data, 8'h00);
    endtask

    task automatic t_tx_enable();
        logic [7:0] v;
        tx_enable = 0; cyc();
        chk("R5 enable low forces TXE", rd_data[7:0], 8'h80);
        bus_read(v); bus_write(8'h00);
        chk("R5 zero write while disabled", rd_data, 8'h80);
        tx_enable = 1; cyc();
        bus_read(v); bus_write(8'h00);
    endtask

    task automatic t_rx_paths();
        frame(1, 0, 0, 0, "R7 framing err no load");
        chk("R9 framing flag, R7 RXF unchanged", rd_data, 8'h10);
        frame(0, 1, 0, 0, "R7 parity err no load");
        chk("R9 parity flag", rd_data, 8'h18);
        frame(0, 0, 1, 1, "R6 clean frame load");
        chk("R6 RXF set, R11 mpb captured", rd_data, 8'h5A);
        frame(0, 0, 0, 0, "R8 overrun blocks load");
        chk("R8 overrun set RXF kept, R11 mpb updated", rd_data, 8'h78);
    endtask

    task automatic t_standby_tfin();
        standby = 1; rx_done = 1;
        #1 chk("R10 no load in standby", {7'd0, rx_load}, 8'h00);
        cyc(); rx_done = 0; standby = 0;
        chk("R10 standby clears RXF keeps errors", rd_data, 8'hB8);
        tx_finished = 1; #1;
        chk("R11 tfin follows", rd_data, 8'hBC);
        tx_finished = 0; #1;
        chk("R11 tfin low", rd_data, 8'hB8);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_write_rules();
        t_set_beats_clear();
        t_tx_enable();
        t_rx_paths();
        t_standby_tfin();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule